// File: doc/BRIEF.md
# Misaligned Word Access Sequencer

This block sits between a requester and a 16-bit memory in which every 20-bit address names one byte. The requester asks for a byte or a 16-bit word, read or write, at any byte address. The sequencer turns that request into one or two even-aligned cycles on the memory port and drives per-lane byte enables so that a write changes only the bytes it names. On a read it picks the right byte lanes out of the returned bus words and assembles the result with the lower-addressed byte in bits 7:0. A word at an even address needs one bus cycle. A word at an odd address needs two: first the even word just below it, of which only the upper lane is used, then the even word just above it, of which only the lower lane is used.

The memory completes a cycle in the clock edge where it holds `mem_ready` high. While `mem_ready` is low the sequencer keeps every bus output steady. The sequencer takes a new request only when it is idle. It signals the end of a request with a one-clock `done` pulse, and the assembled read data is valid in that clock.

The controller has four states. IDLE: `req_ready` is high, and IDLE goes to LEAD when `req_valid` is seen. LEAD: the first bus cycle. On ready it goes to TAIL for an odd-address word and to DONE otherwise. TAIL: the second bus cycle of a split word, which goes to DONE on ready. DONE: `done` is high for one clock, then the controller returns to IDLE.

Top module: `split_access_seq`

## Requirements
- R1: After reset `req_ready` is 1 and both `mem_valid` and `done` are 0.
- R2: A word at an even address A makes exactly one bus cycle, at address A, with `mem_be` = 2'b11 (bit 0 enables bits 7:0 = lower address, bit 1 enables bits 15:8 = upper address).
- R3: A word at an odd address A makes exactly two bus cycles. The first is at A-1 with `mem_be` = 2'b10 and the second is at A+1 with `mem_be` = 2'b01.
- R4: A word read returns {byte at A+1, byte at A} on `rdata`, whether A is even or odd.
- R5: A byte access makes one bus cycle at A with bit 0 cleared. It uses `mem_be` = 2'b01 for even A and 2'b10 for odd A. A byte read returns the selected lane zero-extended in `rdata[7:0]`.
- R6: A write changes only the addressed bytes. The write data's low byte goes to address A and, for a word, its high byte goes to A+1. Lanes that are not enabled carry zero on `mem_wdata`.
- R7: While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr`, `mem_be`, `mem_wdata` and `mem_valid` stay unchanged into the next clock. Results are unaffected by any number of wait clocks.
- R8: `done` is high for exactly one clock after the last bus cycle completes, and `rdata` holds the assembled read data in that clock.
- R9: A request is accepted only while `req_ready` is 1, which is only in IDLE. A request held on the inputs during a transfer starts no bus cycle.
- R10: An odd word at address 20'hFFFFF places its second cycle at address 20'h00000 (the address wraps).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address of the access |
| req_wdata | input | 16 | Write data, low byte at the lower address |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled read data, valid with `done` |
| mem_valid | output | 1 | Bus cycle in progress |
| mem_write | output | 1 | Bus cycle is a write |
| mem_addr | output | 20 | Even word address of the bus cycle |
| mem_be | output | 2 | Byte-lane enables: bit 0 low lane, bit 1 high lane |
| mem_wdata | output | 16 | Bus write data, disabled lanes zero |
| mem_rdata | input | 16 | Bus read data |
| mem_ready | input | 1 | Memory completes the cycle at this edge |

## Verification
A completing memory acknowledge and a pending but unacceptable new request can fall in the same clock: the requester keeps `req_valid` high with a changed address during the whole transfer, including the clock where the last `mem_ready` lands. This case is provoked in directed and random runs, both with wait clocks and without. It is judged by counting the bus handshakes and their addresses against the expected one or two, and by checking that no further cycle starts after `done`. Memory acknowledges are randomised so that wait states fall in both halves of a split word.

// File: rtl/sas_pkg.sv
package sas_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_TAIL = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/sas_fsm.sv
module sas_fsm
    import sas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic split,
    input  logic mem_ready,
    output logic req_ready,
    output logic mem_valid,
    output logic in_tail,
    output logic lead_ack,
    output logic tail_ack,
    output logic done
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_LEAD;
            ST_LEAD: if (mem_ready) state_d = split ? ST_TAIL : ST_DONE;
            ST_TAIL: if (mem_ready) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        mem_valid = 1'b0;
        in_tail   = 1'b0;
        lead_ack  = 1'b0;
        tail_ack  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_LEAD: begin
                mem_valid = 1'b1;
                lead_ack  = mem_ready;
            end
            ST_TAIL: begin
                mem_valid = 1'b1;
                in_tail   = 1'b1;
                tail_ack  = mem_ready;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sas_lanes.sv
module sas_lanes #(
    parameter int LANE_W = 8
) (
    input  logic                word,
    input  logic                odd,
    input  logic                tail,
    input  logic [2*LANE_W-1:0] wdata,
    input  logic [2*LANE_W-1:0] bus_rdata,
    output logic [1:0]          be,
    output logic [2*LANE_W-1:0] bus_wdata,
    output logic [LANE_W-1:0]   lead_lo,
    output logic [LANE_W-1:0]   lead_hi,
    output logic [LANE_W-1:0]   tail_hi
);
    logic [LANE_W-1:0] src_lane [2];

    always_comb begin
        if (word && !odd)  be = 2'b11;
        else if (tail)     be = 2'b01;
        else if (odd)      be = 2'b10;
        else               be = 2'b01;
    end

    // Low bus lane carries the word's high byte only in the tail cycle.
    assign src_lane[0] = tail ? wdata[2*LANE_W-1:LANE_W] : wdata[LANE_W-1:0];
    // High bus lane carries the high byte only for an aligned word.
    assign src_lane[1] = (word && !odd) ? wdata[2*LANE_W-1:LANE_W] : wdata[LANE_W-1:0];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign bus_wdata[g*LANE_W +: LANE_W] = be[g] ? src_lane[g] : '0;
    end

    assign lead_lo = odd ? bus_rdata[2*LANE_W-1:LANE_W] : bus_rdata[LANE_W-1:0];
    assign lead_hi = (word && !odd) ? bus_rdata[2*LANE_W-1:LANE_W] : '0;
    assign tail_hi = bus_rdata[LANE_W-1:0];
endmodule

// File: rtl/split_access_seq.sv
module split_access_seq
    import sas_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_word,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*LANE_W-1:0] req_wdata,
    output logic                req_ready,
    output logic                done,
    output logic [2*LANE_W-1:0] rdata,
    output logic                mem_valid,
    output logic                mem_write,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [1:0]          mem_be,
    output logic [2*LANE_W-1:0] mem_wdata,
    input  logic [2*LANE_W-1:0] mem_rdata,
    input  logic                mem_ready
);
    localparam int DATA_W = 2 * LANE_W;

    logic              q_write, q_word;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic [LANE_W-1:0] res_lo, res_hi;

    logic accept, in_tail, lead_ack, tail_ack;
    logic [LANE_W-1:0] lead_lo, lead_hi, tail_hi;
    logic [ADDR_W-1:0] lead_addr;

    assign accept = req_valid && req_ready;

    sas_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_valid),
        .split     (q_word && q_addr[0]),
        .mem_ready (mem_ready),
        .req_ready (req_ready),
        .mem_valid (mem_valid),
        .in_tail   (in_tail),
        .lead_ack  (lead_ack),
        .tail_ack  (tail_ack),
        .done      (done)
    );

    sas_lanes #(.LANE_W(LANE_W)) u_lanes (
        .word      (q_word),
        .odd       (q_addr[0]),
        .tail      (in_tail),
        .wdata     (q_wdata),
        .bus_rdata (mem_rdata),
        .be        (mem_be),
        .bus_wdata (mem_wdata),
        .lead_lo   (lead_lo),
        .lead_hi   (lead_hi),
        .tail_hi   (tail_hi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_word  <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
        end else if (accept) begin
            q_write <= req_write;
            q_word  <= req_word;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
        end else if (accept) begin
            res_lo <= '0;
            res_hi <= '0;
        end else if (lead_ack && !q_write) begin
            res_lo <= lead_lo;
            res_hi <= lead_hi;
        end else if (tail_ack && !q_write) begin
            res_hi <= tail_hi;
        end
    end

    assign lead_addr = {q_addr[ADDR_W-1:1], 1'b0};
    assign mem_addr  = in_tail ? lead_addr + ADDR_W'(2) : lead_addr;
    assign mem_write = mem_valid && q_write;
    assign rdata     = {res_hi, res_lo};
endmodule

// File: rtl/sas_checker.sv
module sas_checker #(
    parameter int ADDR_W = 20,
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                done,
    input logic                mem_valid,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [1:0]          mem_be,
    input logic [2*LANE_W-1:0] mem_wdata,
    input logic                mem_ready
);
    // R2 / R3 / R5: bus cycles are always on even word addresses
    a_r2_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !mem_addr[0]);

    // R6: every bus cycle enables at least one lane
    a_r6_lane_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_be) >= 1));

    // R7: outputs held steady while the memory stalls
    a_r7_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_be) && $stable(mem_wdata)));

    // R8: completion is a single-clock pulse with no bus activity
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_valid);

    // R9: no request taken while a transfer is under way
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || done) |-> !req_ready);
endmodule

bind split_access_seq sas_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/sim_split_access_seq.sv
`timescale 1ns/1ps
module sim_split_access_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done, mem_valid, mem_write;
    logic [15:0] rdata, mem_wdata;
    logic [19:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int checks = 0, errors = 0;
    int hs_count = 0;
    bit stall_mode = 0;
    bit finished = 0;
    logic [19:0] log_addr [4];
    logic [1:0]  log_be [4];
    logic [7:0]  mem [int];

    always #2.5 clk = ~clk;

    split_access_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    function automatic logic [7:0] rb(input logic [19:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'hA5;
    endfunction

    // Memory model: decides the acknowledge away from the active edge.
    always @(negedge clk) begin
        if (mem_valid) begin
            logic rdy;
            rdy = stall_mode ? (($urandom % 3) == 0) : 1'b1;
            mem_rdata = {rb(mem_addr + 20'd1), rb(mem_addr)};
            if (rdy) begin
                if (hs_count < 4) begin
                    log_addr[hs_count] = mem_addr;
                    log_be[hs_count]   = mem_be;
                end
                hs_count++;
                if (mem_write) begin
                    if (mem_be[0]) mem[int'(mem_addr)] = mem_wdata[7:0];
                    if (mem_be[1]) mem[int'(mem_addr + 20'd1)] = mem_wdata[15:8];
                end
            end
            mem_ready = rdy;
        end else begin
            mem_ready = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic wr, input logic word, input logic [19:0] a,
                         input logic [15:0] wd, input bit hold);
        logic [15:0] exp_rd, got;
        logic [7:0]  nb_a, nb_b;
        logic [19:0] a1, e0, e1;
        logic [1:0]  be0;
        int          n_exp;
        string       lc, ld;
        a1     = a + 20'd1;
        exp_rd = word ? {rb(a1), rb(a)} : {8'h00, rb(a)};
        nb_a   = word ? rb(a - 20'd1) : rb(a ^ 20'd1);
        nb_b   = word ? rb(a + 20'd2) : rb(a ^ 20'd1);
        n_exp  = (word && a[0]) ? 2 : 1;
        e0     = {a[19:1], 1'b0};
        e1     = e0 + 20'd2;
        be0    = word ? (a[0] ? 2'b10 : 2'b11) : (a[0] ? 2'b10 : 2'b01);
        lc     = hold ? "R9" : (word ? (a[0] ? "R3" : "R2") : "R5");
        ld     = stall_mode ? "R7" : (word ? "R4" : "R5");

        @(negedge clk);
        hs_count  = 0;
        req_valid = 1'b1; req_write = wr; req_word = word;
        req_addr  = a; req_wdata = wd;
        @(negedge clk);
        if (hold) begin
            req_addr  = a ^ 20'h00400;
            req_word  = ~word;
        end else begin
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        got       = rdata;
        req_valid = 1'b0;
        @(negedge clk);
        chk(!done, "R8", {31'd0, done}, 32'd0);
        chk(hs_count == n_exp, lc, hs_count, n_exp);
        chk(log_addr[0] == e0, lc, {12'd0, log_addr[0]}, {12'd0, e0});
        chk(log_be[0] == be0, lc, {30'd0, log_be[0]}, {30'd0, be0});
        if (n_exp == 2 && hs_count >= 2) begin
            chk(log_addr[1] == e1, (a == 20'hFFFFF) ? "R10" : "R3",
                {12'd0, log_addr[1]}, {12'd0, e1});
            chk(log_be[1] == 2'b01, "R3", {30'd0, log_be[1]}, 32'd1);
        end
        if (!wr) begin
            chk(got == exp_rd, ld, {16'd0, got}, {16'd0, exp_rd});
        end else begin
            chk(rb(a) == wd[7:0], "R6", {24'd0, rb(a)}, {24'd0, wd[7:0]});
            if (word) begin
                chk(rb(a1) == wd[15:8], "R6", {24'd0, rb(a1)}, {24'd0, wd[15:8]});
                chk(rb(a - 20'd1) == nb_a, "R6", {24'd0, rb(a - 20'd1)}, {24'd0, nb_a});
                chk(rb(a + 20'd2) == nb_b, "R6", {24'd0, rb(a + 20'd2)}, {24'd0, nb_b});
            end else begin
                chk(rb(a ^ 20'd1) == nb_b, "R6", {24'd0, rb(a ^ 20'd1)}, {24'd0, nb_b});
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", {31'd0, req_ready}, 32'd1);
        chk(mem_valid == 1'b0, "R1", {31'd0, mem_valid}, 32'd0);
        chk(done == 1'b0, "R1", {31'd0, done}, 32'd0);

        // Directed corner cases, no wait states
        do_op(1'b0, 1'b1, 20'h00520, 16'h0, 0);      // R2, R4 aligned word read
        do_op(1'b0, 1'b1, 20'h00521, 16'h0, 0);      // R3, R4 odd word read
        do_op(1'b0, 1'b0, 20'h00520, 16'h0, 0);      // R5 even byte
        do_op(1'b0, 1'b0, 20'h00521, 16'h0, 0);      // R5 odd byte
        do_op(1'b1, 1'b1, 20'h00601, 16'hBEEF, 0);   // R6 odd word write
        do_op(1'b0, 1'b1, 20'h00601, 16'h0, 0);      // R4 read back
        do_op(1'b1, 1'b0, 20'h00603, 16'h0077, 0);   // R6 odd byte write
        do_op(1'b1, 1'b1, 20'h00700, 16'h1234, 0);   // R6 aligned word write
        do_op(1'b0, 1'b1, 20'hFFFFF, 16'h0, 0);      // R10 wrap
        do_op(1'b0, 1'b1, 20'h00333, 16'h0, 1);      // R9 held request
        stall_mode = 1;
        do_op(1'b0, 1'b1, 20'h00455, 16'h0, 1);      // R7 + R9 under stalls
        do_op(1'b1, 1'b1, 20'h00455, 16'hA55A, 0);   // R7 write under stalls
        do_op(1'b0, 1'b1, 20'h00455, 16'h0, 0);      // R7 read back

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            logic [19:0] a;
            stall_mode = ($urandom % 2) == 1;
            if (($urandom % 5) == 0) a = 20'hFFFF8 + 20'($urandom % 8);
            else                     a = 20'h00100 + 20'($urandom % 48);
            do_op(1'($urandom % 2), 1'($urandom % 2), a, 16'($urandom), ($urandom % 4) == 0);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule